// File: doc/BRIEF.md
# Counted-Enable Interrupt Source Aggregator

This block sits between a group of interrupt-raising devices and one CPU request line. Each source has a level request input and an enable counter. Software mask operations move the counter up or down by one, and the source counts as enabled only while the counter equals a required total fixed for that source. A source is pending when its request is high and it is enabled. The block keeps a running tally of pending sources and raises the CPU request while that tally is non-zero. The CPU presents its current mask level and receives, with no clock delay, the vector of the lowest-numbered pending source.

A mask operation names one table entry. A table entry is either a source, which has a non-zero vector, or a group, which has no vector but links to a first member. A toggle on a group walks the link chain and adjusts every source it reaches. The source table (vectors, required totals, links) is fixed by parameters. The default table has eight entries: entry 0 has vector 0x000 and total 1. Entries 1 to 5 are sources with vectors 0x100, 0x120, 0x140, 0x160 and 0x180 and totals 1, 2, 1, 1 and 2. Entry 6 is a group linking to 3, and 3 links to 4, 4 to 5. Entry 7 has vector 0x1E0, total 0 and no link.

Top module: `irq_source_agg`

## Requirements
- R1: A toggle with `tgl_set`=1 adds one to each targeted source's 3-bit enable counter and `tgl_set`=0 subtracts one; an increment at 7 and a decrement at 0 leave the counter unchanged.
- R2: A source is pending exactly when its `src_req` bit is 1 and its counter equals its required total; entry 7 (total 0) is pending whenever its request is high, and the pending tally always equals the number of pending sources.
- R3: `cpu_irq` rises when the pending tally leaves 0 and falls when it returns to 0; request and toggle changes sampled at one rising edge appear on `cpu_irq` right after that same edge.
- R4: When `cpu_level` is not 0xF, `sel_valid` is 1 exactly when some source is pending, and `sel_vec` is the vector of the lowest-index pending source.
- R5: When `cpu_level` is 0xF, `sel_valid` is 0 and `sel_vec` is 0 whatever is pending; other level values do not change the selection.
- R6: A toggle aimed at entry 0, or at an entry with no link whose vector or required total is 0 (entry 7 by default), changes no counter.
- R7: A toggle on a group entry (6) adjusts every source along its link chain (3, 4, 5); a toggle aimed directly at a source that has a link (3) adjusts only that source.
- R8: While `rst_n` is 0 at a rising edge, all counters, pending flags, the tally and `cpu_irq` are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | NUM_SRC | Level request per source |
| tgl_valid | input | 1 | A mask toggle is presented this cycle |
| tgl_id | input | ID_W | Table entry the toggle targets |
| tgl_set | input | 1 | 1 = count up (enable), 0 = count down (disable) |
| cpu_level | input | 4 | Current CPU mask level |
| cpu_irq | output | 1 | Request to the CPU |
| sel_valid | output | 1 | A vector is offered |
| sel_vec | output | VEC_W | Vector of the selected pending source |

## Verification
Counters, pending flags, the tally and `cpu_irq` all update at the rising edge that samples a request or toggle, so each is due one edge after the stimulus is driven. The selection is combinational on the registered pending flags and on `cpu_level`, so it is due in the same window. The bench drives inputs at the falling edge and compares 2 ns after the next rising edge, against a model updated for exactly that one edge. The level is held across that window so the combinational path is stable at the compare.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt source aggregator.
// Assumes a 4-bit CPU mask level where the all-ones value blocks selection.
package irq_agg_pkg;
    localparam int LEVEL_W = 4;
    localparam logic [LEVEL_W-1:0] LEVEL_BLOCK = 4'hF;

    typedef enum logic {
        TGL_DOWN = 1'b0,
        TGL_UP   = 1'b1
    } tgl_dir_e;
endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source: a saturating up/down enable counter and a pending
// flag. Assumes at most one toggle step per cycle. The next pending value
// is exported so a tally can count transitions at the same edge.
module irq_src_slot
    import irq_agg_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter logic [CNT_W-1:0] NEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic up,
    input  logic req,
    output logic pend_d,
    output logic pend_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next counter value: one step toward the toggle, held at both ends.
    always_comb begin
        cnt_d = cnt_q;
        if (hit) begin
            if (tgl_dir_e'(up) == TGL_UP) begin
                if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
            end else begin
                if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            end
        end
        pend_d = req && (cnt_d == NEED);
    end

    // Register counter and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/irq_pend_tally.sv
// Running count of pending sources, moved by the number of sources that
// become pending minus those that stop, and the CPU request derived from
// the count leaving or returning to zero.
module irq_pend_tally #(
    parameter int NUM_SRC = 8,
    parameter int TALLY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_d,
    input  logic [NUM_SRC-1:0] pend_q,
    output logic [TALLY_W-1:0] count_q,
    output logic               irq_q
);
    logic [TALLY_W-1:0] ups;
    logic [TALLY_W-1:0] downs;
    logic [TALLY_W-1:0] count_d;
    logic               irq_d;

    // Count rising and falling pending flags and form the next tally.
    always_comb begin
        ups   = '0;
        downs = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            ups   = ups   + TALLY_W'(pend_d[i] & ~pend_q[i]);
            downs = downs + TALLY_W'(~pend_d[i] & pend_q[i]);
        end
        count_d = count_q + ups - downs;
        irq_d   = irq_q;
        if (count_q == '0 && count_d != '0) irq_d = 1'b1;
        else if (count_d == '0)             irq_d = 1'b0;
    end

    // Register tally and CPU request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            irq_q   <= irq_d;
        end
    end
endmodule

// File: rtl/irq_vec_pick.sv
// Combinational vector selection: lowest-index pending source wins,
// nothing is offered while the CPU mask level is at its blocking value.
module irq_vec_pick
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 12,
    parameter logic [NUM_SRC*VEC_W-1:0] VEC_TAB = '0
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [LEVEL_W-1:0] level,
    output logic               valid,
    output logic [VEC_W-1:0]   vec
);
    // Scan from the top so the lowest pending index is written last.
    always_comb begin
        valid = 1'b0;
        vec   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                valid = 1'b1;
                vec   = VEC_TAB[i*VEC_W +: VEC_W];
            end
        end
        if (level == LEVEL_BLOCK) begin
            valid = 1'b0;
            vec   = '0;
        end
    end
endmodule

// File: rtl/irq_source_agg.sv
// Top of the interrupt source aggregator. The source table is fixed by
// parameters; for every entry the set of sources a toggle reaches is
// resolved at elaboration by walking the link chain, so a toggle (group or
// single) lands on all its sources in one cycle. Assumes link chains are
// no longer than NUM_SRC hops.
module irq_source_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3,
    parameter int CNT_W   = 3,
    parameter int VEC_W   = 12,
    parameter logic [NUM_SRC*VEC_W-1:0] SRC_VEC =
        {12'h1E0, 12'h000, 12'h180, 12'h160, 12'h140, 12'h120, 12'h100, 12'h000},
    parameter logic [NUM_SRC*CNT_W-1:0] SRC_NEED =
        {3'd0, 3'd1, 3'd2, 3'd1, 3'd1, 3'd2, 3'd1, 3'd1},
    parameter logic [NUM_SRC*ID_W-1:0] SRC_LINK =
        {3'd0, 3'd3, 3'd0, 3'd5, 3'd4, 3'd0, 3'd0, 3'd0}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               tgl_valid,
    input  logic [ID_W-1:0]    tgl_id,
    input  logic               tgl_set,
    input  logic [LEVEL_W-1:0] cpu_level,
    output logic               cpu_irq,
    output logic               sel_valid,
    output logic [VEC_W-1:0]   sel_vec
);
    localparam int TALLY_W = $clog2(NUM_SRC + 1);

    // Sources reached by a toggle aimed at entry 'start'.
    function automatic logic [NUM_SRC-1:0] reach_of(input int start);
        logic [NUM_SRC-1:0] m;
        int  cur;
        int  nxt;
        bit  grp;
        bit  live;
        bit  has_vec;
        m    = '0;
        cur  = start;
        grp  = 1'b0;
        live = 1'b1;
        for (int h = 0; h < NUM_SRC; h++) begin
            if (live) begin
                nxt     = int'(SRC_LINK[cur*ID_W +: ID_W]);
                has_vec = (SRC_VEC[cur*VEC_W +: VEC_W] != '0);
                if (cur == 0 || (nxt == 0 &&
                    (SRC_NEED[cur*CNT_W +: CNT_W] == '0 || !has_vec))) begin
                    live = 1'b0;
                end else begin
                    if (has_vec) m[cur] = 1'b1;
                    if ((grp || !has_vec) && nxt != 0 && nxt < NUM_SRC) begin
                        cur = nxt;
                        grp = 1'b1;
                    end else begin
                        live = 1'b0;
                    end
                end
            end
        end
        return m;
    endfunction

    logic [NUM_SRC-1:0] reach_map [NUM_SRC];
    logic [NUM_SRC-1:0] hits;
    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] pend_q;
    logic [TALLY_W-1:0] tally_cnt;

    // Per-entry reach table and per-source slots.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [NUM_SRC-1:0] REACH = reach_of(g);
        assign reach_map[g] = REACH;

        irq_src_slot #(
            .CNT_W (CNT_W),
            .NEED  (SRC_NEED[g*CNT_W +: CNT_W])
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hits[g]),
            .up     (tgl_set),
            .req    (src_req[g]),
            .pend_d (pend_d[g]),
            .pend_q (pend_q[g])
        );
    end

    // Select the sources touched by this cycle's toggle.
    always_comb begin
        hits = '0;
        if (tgl_valid && int'(tgl_id) < NUM_SRC) hits = reach_map[tgl_id];
    end

    irq_pend_tally #(
        .NUM_SRC (NUM_SRC),
        .TALLY_W (TALLY_W)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_d  (pend_d),
        .pend_q  (pend_q),
        .count_q (tally_cnt),
        .irq_q   (cpu_irq)
    );

    irq_vec_pick #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W),
        .VEC_TAB (SRC_VEC)
    ) u_pick (
        .pend  (pend_q),
        .level (cpu_level),
        .valid (sel_valid),
        .vec   (sel_vec)
    );
endmodule

// File: rtl/irq_agg_chk.sv
// Property checker for the aggregator, attached by bind. Observes the
// top-level ports plus the registered pending flags and the tally.
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int TALLY_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LEVEL_W-1:0] cpu_level,
    input logic               cpu_irq,
    input logic               sel_valid,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [TALLY_W-1:0] tally_cnt
);
    a_r2_tally_equals_pending: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tally_cnt) == $countones(pend_q));

    a_r3_irq_follows_tally: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (tally_cnt != '0));

    a_r3_rise_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(tally_cnt) == '0);

    a_r4_valid_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_level != LEVEL_BLOCK |-> sel_valid == (pend_q != '0));

    a_r5_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_level == LEVEL_BLOCK |-> !sel_valid);

    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (tally_cnt == '0 && !cpu_irq && pend_q == '0));
endmodule

bind irq_source_agg irq_agg_chk #(
    .NUM_SRC (NUM_SRC),
    .TALLY_W (TALLY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_level (cpu_level),
    .cpu_irq   (cpu_irq),
    .sel_valid (sel_valid),
    .pend_q    (pend_q),
    .tally_cnt (tally_cnt)
);

// File: tb/irq_source_agg_tb.sv
`timescale 1ns/1ps
module irq_source_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  src_req;
    logic        tgl_valid;
    logic [2:0]  tgl_id;
    logic        tgl_set;
    logic [3:0]  cpu_level;
    logic        cpu_irq;
    logic        sel_valid;
    logic [11:0] sel_vec;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state.
    int m_cnt [8];
    bit m_pend [8];

    always #5 clk = ~clk;

    irq_source_agg u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .tgl_valid (tgl_valid),
        .tgl_id    (tgl_id),
        .tgl_set   (tgl_set),
        .cpu_level (cpu_level),
        .cpu_irq   (cpu_irq),
        .sel_valid (sel_valid),
        .sel_vec   (sel_vec)
    );

    function automatic int need_of(input int i);
        case (i)
            2, 5:    return 2;
            7:       return 0;
            default: return 1;
        endcase
    endfunction

    function automatic logic [11:0] vec_of(input int i);
        case (i)
            1: return 12'h100;
            2: return 12'h120;
            3: return 12'h140;
            4: return 12'h160;
            5: return 12'h180;
            7: return 12'h1E0;
            default: return 12'h000;
        endcase
    endfunction

    // R6 / R7: which sources a toggle of each entry reaches.
    function automatic logic [7:0] members(input int id);
        case (id)
            1, 2, 3, 4, 5: return 8'(1 << id);
            6:              return 8'b0011_1000;
            default:        return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_cnt[i]  = 0;
            m_pend[i] = 0;
        end
    endtask

    // Apply one cycle of stimulus (called at a falling edge), update the
    // model for the next rising edge, then compare 2 ns after that edge.
    task automatic step(input logic [7:0] req, input bit tv, input int id,
                        input bit set, input logic [3:0] lvl, input string tag);
        logic [7:0] mem;
        bit         exp_irq;
        bit         exp_val;
        logic [11:0] exp_vec;
        src_req   = req;
        tgl_valid = tv;
        tgl_id    = 3'(id);
        tgl_set   = set;
        cpu_level = lvl;
        mem = tv ? members(id) : 8'h00;
        exp_irq = 0;
        exp_val = 0;
        exp_vec = 12'h000;
        for (int i = 0; i < 8; i++) begin
            if (mem[i]) begin
                if (set && m_cnt[i] < 7) m_cnt[i]++;
                else if (!set && m_cnt[i] > 0) m_cnt[i]--;
            end
            m_pend[i] = req[i] && (m_cnt[i] == need_of(i));
            if (m_pend[i]) exp_irq = 1;
        end
        for (int i = 7; i >= 0; i--) begin
            if (m_pend[i]) begin
                exp_val = 1;
                exp_vec = vec_of(i);
            end
        end
        if (lvl == 4'hF) begin
            exp_val = 0;
            exp_vec = 12'h000;
        end
        @(posedge clk);
        #2;
        check(cpu_irq == exp_irq, {tag, " R3 irq"}, int'(cpu_irq), int'(exp_irq));
        check(sel_valid == exp_val && sel_vec == exp_vec,
              {tag, (lvl == 4'hF) ? " R5 sel" : " R4 sel"},
              int'({sel_valid, sel_vec}), int'({exp_val, exp_vec}));
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n     = 1'b0;
        src_req   = 8'hFF;
        tgl_valid = 1'b1;
        tgl_id    = 3'd1;
        tgl_set   = 1'b1;
        cpu_level = 4'h0;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        // R8: everything held clear while in reset, even with requests high.
        check(cpu_irq == 1'b0, "R8 irq in reset", int'(cpu_irq), 0);
        check(sel_valid == 1'b0, "R8 sel in reset", int'(sel_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: entry 7 (total 0) pending on request alone.
        step(8'hFF, 0, 0, 0, 4'h0, "R2 total-zero source");
        // R6: toggles on entry 7 and entry 0 change nothing.
        step(8'hFF, 1, 7, 1, 4'h0, "R6 reserved entry");
        step(8'hFF, 1, 0, 1, 4'h0, "R6 entry zero");
        // R4: source 1 enabled wins over 7.
        step(8'hFF, 1, 1, 1, 4'h3, "R4 lowest index");
        // R1: down, saturate at 0, back up.
        step(8'hFF, 1, 1, 0, 4'h0, "R1 decrement");
        step(8'hFF, 1, 1, 0, 4'h0, "R1 floor");
        step(8'hFF, 1, 1, 1, 4'h0, "R1 after floor");
        step(8'hFF, 1, 1, 0, 4'h0, "R1 decrement again");
        // R7: direct toggle on linked source 3 does not forward.
        step(8'hEF, 1, 3, 1, 4'h0, "R7 direct linked");
        step(8'hF7, 0, 0, 0, 4'h0, "R7 no forward to 4");
        step(8'hFF, 1, 3, 0, 4'h0, "R7 undo 3");
        // R7: group toggle reaches 3, 4, 5.
        step(8'hFF, 1, 6, 1, 4'h0, "R7 group");
        step(8'hF7, 0, 0, 0, 4'h0, "R7 member 4");
        step(8'hE7, 0, 0, 0, 4'h0, "R7 member 5 partial");
        step(8'hE7, 1, 5, 1, 4'h0, "R7 member 5 full");
        // R5: blocking level hides the selection, request stays.
        step(8'hFF, 0, 0, 0, 4'hF, "R5 level block");
        // R3: all requests off drops the CPU request.
        step(8'h00, 0, 0, 0, 4'h0, "R3 drop");
        step(8'h02, 0, 0, 0, 4'h0, "R3 tally empty");
        // R1: saturation at 7 on source 2.
        for (int k = 0; k < 9; k++) step(8'h04, 1, 2, 1, 4'h0, "R1 ceiling");
        for (int k = 0; k < 5; k++) step(8'h04, 1, 2, 0, 4'h0, "R1 down from ceiling");

        // Constrained random mix.
        for (int k = 0; k < 1500; k++) begin
            logic [7:0] rq;
            int         lv;
            rq = 8'($urandom);
            lv = (($urandom % 4) == 0) ? 15 : int'($urandom % 15);
            step(rq, ($urandom % 3) != 0, int'($urandom % 8), ($urandom % 2) != 0,
                 4'(lv), "random");
        end

        // R8: reset in mid-run clears state.
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check(cpu_irq == 1'b0, "R8 mid-run reset", int'(cpu_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        step(8'h3E, 0, 0, 0, 4'h0, "R8 counters cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule